// File: doc/BRIEF.md
# Two-Bank Level Interrupt Controller

This block gathers 64 level-sensitive peripheral interrupt lines and 8 level-sensitive local interrupt lines into a single combined IRQ output and a single fast-interrupt (FIQ) output. Each source has its own enable bit. Software changes the enable masks only through write-one-to-set and write-one-to-clear registers, so one write never disturbs the enables it does not name.

The IRQ output is the OR of every enabled, active source in both banks. The FIQ output follows the raw level of exactly one source, which software picks by index through a control register. FIQ ignores the enable masks.

A summary word gives a fast first look at what is pending. It holds:
- the masked local bits;
- one "any pending" flag for each half of the peripheral bank;
- copies of eleven chosen peripheral sources, so that a handler can often find its source without a second read.

Software reaches the block through a 32-bit register port that uses byte offsets. Reads are combinational. Writes take effect at the clock edge. Both interrupt outputs are registered.

Top module: `intc2b_top`

## Requirements
- R1: Source inputs are not latched. Offset 0x04 reads peripheral levels 31:0 ANDed with their enables. Offset 0x08 reads peripheral levels 63:32 ANDed with their enables.
- R2: A write to 0x10 ORs the data into peripheral enables 31:0. A write to 0x14 ORs the data into enables 63:32. A write to 0x18 ORs data bits 7:0 into the local enables. Reading any of these three offsets returns the enable mask it controls, zero-extended to 32 bits.
- R3: A write to 0x1C, 0x20 or 0x24 clears each enable whose data bit is 1, in the same mask that 0x10, 0x14 or 0x18 sets. Reading 0x1C, 0x20 or 0x24 returns the 32-bit bitwise inverse of the zero-extended mask, so bits 31:8 of 0x24 read as ones.
- R4: In the summary word at 0x00:
  - bits 7:0 are the masked local sources;
  - bit 8 is set when any of peripheral sources 0–31 is both active and enabled;
  - bit 9 is set when any of peripheral sources 32–63 is both active and enabled.
- R5: Summary bits 10 to 20 hold, in ascending order, the masked pending state of peripheral sources 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62. Bits 31:21 read 0.
- R6: At offset 0x0C, a write stores data bits 6:0 as the FIQ select and data bit 7 as the FIQ enable. A read returns {24'b0, enable, select}.
- R7: FIQ output:
  - when the FIQ enable is 1 and the select is 0–63, FIQ follows the raw level of that peripheral source;
  - when the FIQ enable is 1 and the select is 64–71, FIQ follows the raw level of local source (select − 64);
  - the enable masks have no effect on FIQ;
  - when the FIQ enable is 0, FIQ is 0.
- R8: A FIQ select of 72 to 127 selects no source, so the FIQ output is 0.
- R9: The IRQ output is 1 exactly when some peripheral or local source is both active and enabled.
- R10: IRQ and FIQ are registered. Each clock edge loads the values that the source levels and register state held just before that edge. A register write therefore appears on the outputs one edge after the write edge.
- R11: An asynchronous active-low reset clears all enables, the FIQ enable and the FIQ select, and both outputs.
- R12: An undefined offset reads 0, and a write to it changes nothing. Offsets 0x28–0x3C and any address with bits 1:0 not zero are undefined. Writes to 0x00, 0x04 and 0x08 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_lvl | input | 64 | Peripheral source levels |
| local_lvl | input | 8 | Local source levels |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | 6 | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| irq_out | output | 1 | Registered combined IRQ |
| fiq_out | output | 1 | Registered FIQ |

## Verification
The bench builds the block with its default parameters: 64 peripheral and 8 local sources, a 32-bit word and a 6-bit offset. The 6-bit offset reaches every defined register, the undefined offsets above 0x24 and unaligned addresses. The 7-bit select field covers every peripheral index, every local index and the empty range 72–127. Random sparse source patterns exercise each peripheral half flag on its own. Directed writes hit the boundary selects 63, 64, 71 and 72.

// File: rtl/intc2b_pkg.sv
package intc2b_pkg;
    localparam int PERIPH_N = 64;
    localparam int LOCAL_N  = 8;
    localparam int WORD_W   = 32;
    localparam int ADDR_W   = 6;
    localparam int SEL_W    = 7;
    localparam int SHORT_N  = 11;

    typedef enum logic [ADDR_W-1:0] {
        OFF_SUMMARY = 6'h00,
        OFF_PEND_LO = 6'h04,
        OFF_PEND_HI = 6'h08,
        OFF_FIQ     = 6'h0C,
        OFF_ENS_LO  = 6'h10,
        OFF_ENS_HI  = 6'h14,
        OFF_ENS_LOC = 6'h18,
        OFF_ENC_LO  = 6'h1C,
        OFF_ENC_HI  = 6'h20,
        OFF_ENC_LOC = 6'h24
    } reg_off_e;

    // Peripheral source copied into summary bit (10 + k).
    function automatic int shortcut_src(input int k);
        case (k)
            0: return 7;
            1: return 9;
            2: return 10;
            3: return 18;
            4: return 19;
            5: return 53;
            6: return 54;
            7: return 55;
            8: return 56;
            9: return 57;
            default: return 62;
        endcase
    endfunction
endpackage

// File: rtl/intc2b_mask_bank.sv
// One enable mask with write-one-to-set and write-one-to-clear strobes.
module intc2b_mask_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] bits,
    output logic [W-1:0] mask
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (set_stb) begin
            mask <= mask | bits;
        end else if (clr_stb) begin
            mask <= mask & ~bits;
        end
    end
endmodule

// File: rtl/intc2b_fiq_ctl.sv
// FIQ control register and the combinational select of one raw source level.
module intc2b_fiq_ctl #(
    parameter int PERIPH_N = 64,
    parameter int LOCAL_N  = 8,
    parameter int SEL_W    = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_stb,
    input  logic [SEL_W:0]      wbits,
    input  logic [PERIPH_N-1:0] periph_lvl,
    input  logic [LOCAL_N-1:0]  local_lvl,
    output logic                fiq_en,
    output logic [SEL_W-1:0]    fiq_sel,
    output logic                fiq_raw
);
    localparam int PIDX_W = $clog2(PERIPH_N);
    localparam int LIDX_W = $clog2(LOCAL_N);

    logic [SEL_W-1:0] loc_off;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fiq_en  <= 1'b0;
            fiq_sel <= '0;
        end else if (wr_stb) begin
            fiq_en  <= wbits[SEL_W];
            fiq_sel <= wbits[SEL_W-1:0];
        end
    end

    assign loc_off = fiq_sel - SEL_W'(PERIPH_N);

    always_comb begin
        if (fiq_sel < SEL_W'(PERIPH_N)) begin
            fiq_raw = periph_lvl[fiq_sel[PIDX_W-1:0]];
        end else if (fiq_sel < SEL_W'(PERIPH_N + LOCAL_N)) begin
            fiq_raw = local_lvl[loc_off[LIDX_W-1:0]];
        end else begin
            fiq_raw = 1'b0;
        end
    end
endmodule

// File: rtl/intc2b_readmux.sv
// Read-data selection, including the summary word.
module intc2b_readmux
    import intc2b_pkg::*;
#(
    parameter int PERIPH_N = 64,
    parameter int LOCAL_N  = 8,
    parameter int WORD_W   = 32,
    parameter int ADDR_W   = 6,
    parameter int SEL_W    = 7,
    parameter int SHORT_N  = 11
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [PERIPH_N-1:0] pend_p,
    input  logic [LOCAL_N-1:0]  pend_l,
    input  logic [PERIPH_N-1:0] pmask,
    input  logic [LOCAL_N-1:0]  lmask,
    input  logic                fiq_en,
    input  logic [SEL_W-1:0]    fiq_sel,
    output logic [WORD_W-1:0]   rdata
);
    localparam int HALF   = PERIPH_N / 2;
    localparam int SC_LSB = LOCAL_N + 2;

    logic [WORD_W-1:0] summary;
    logic [WORD_W-1:0] loc_mask_w;

    assign loc_mask_w = WORD_W'(lmask);

    always_comb begin
        summary = '0;
        summary[LOCAL_N-1:0] = pend_l;
        summary[LOCAL_N]     = |pend_p[HALF-1:0];
        summary[LOCAL_N+1]   = |pend_p[PERIPH_N-1:HALF];
    end

    logic [SHORT_N-1:0] shortcut;
    for (genvar k = 0; k < SHORT_N; k++) begin : g_short
        assign shortcut[k] = pend_p[shortcut_src(k)];
    end

    always_comb begin
        case (addr)
            OFF_SUMMARY: rdata = summary | (WORD_W'(shortcut) << SC_LSB);
            OFF_PEND_LO: rdata = pend_p[HALF-1:0];
            OFF_PEND_HI: rdata = pend_p[PERIPH_N-1:HALF];
            OFF_FIQ:     rdata = WORD_W'({fiq_en, fiq_sel});
            OFF_ENS_LO:  rdata = pmask[HALF-1:0];
            OFF_ENS_HI:  rdata = pmask[PERIPH_N-1:HALF];
            OFF_ENS_LOC: rdata = loc_mask_w;
            OFF_ENC_LO:  rdata = ~pmask[HALF-1:0];
            OFF_ENC_HI:  rdata = ~pmask[PERIPH_N-1:HALF];
            OFF_ENC_LOC: rdata = ~loc_mask_w;
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/intc2b_top.sv
module intc2b_top
    import intc2b_pkg::*;
#(
    parameter int P_SRC = PERIPH_N,
    parameter int L_SRC = LOCAL_N,
    parameter int DW    = WORD_W,
    parameter int AW    = ADDR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [P_SRC-1:0] periph_lvl,
    input  logic [L_SRC-1:0] local_lvl,
    input  logic             reg_wr,
    input  logic [AW-1:0]    reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             irq_out,
    output logic             fiq_out
);
    localparam int HALF = P_SRC / 2;

    // Write strobes: [0] low half, [1] high half.
    logic [1:0] pset, pclr;
    logic       lset, lclr, fwr;

    always_comb begin
        pset = '0;
        pclr = '0;
        lset = 1'b0;
        lclr = 1'b0;
        fwr  = 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                OFF_ENS_LO:  pset[0] = 1'b1;
                OFF_ENS_HI:  pset[1] = 1'b1;
                OFF_ENC_LO:  pclr[0] = 1'b1;
                OFF_ENC_HI:  pclr[1] = 1'b1;
                OFF_ENS_LOC: lset    = 1'b1;
                OFF_ENC_LOC: lclr    = 1'b1;
                OFF_FIQ:     fwr     = 1'b1;
                default:     ;
            endcase
        end
    end

    logic [P_SRC-1:0] pen_mask;
    logic [L_SRC-1:0] len_mask;

    for (genvar h = 0; h < 2; h++) begin : g_half
        intc2b_mask_bank #(.W(HALF)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_stb (pset[h]),
            .clr_stb (pclr[h]),
            .bits    (reg_wdata[HALF-1:0]),
            .mask    (pen_mask[h*HALF +: HALF])
        );
    end

    intc2b_mask_bank #(.W(L_SRC)) u_local_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (lset),
        .clr_stb (lclr),
        .bits    (reg_wdata[L_SRC-1:0]),
        .mask    (len_mask)
    );

    logic             fiq_en;
    logic [SEL_W-1:0] fiq_sel;
    logic             fiq_raw;

    intc2b_fiq_ctl #(.PERIPH_N(P_SRC), .LOCAL_N(L_SRC), .SEL_W(SEL_W)) u_fiq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (fwr),
        .wbits      (reg_wdata[SEL_W:0]),
        .periph_lvl (periph_lvl),
        .local_lvl  (local_lvl),
        .fiq_en     (fiq_en),
        .fiq_sel    (fiq_sel),
        .fiq_raw    (fiq_raw)
    );

    logic [P_SRC-1:0] pend_p;
    logic [L_SRC-1:0] pend_l;

    assign pend_p = periph_lvl & pen_mask;
    assign pend_l = local_lvl & len_mask;

    intc2b_readmux #(
        .PERIPH_N (P_SRC), .LOCAL_N (L_SRC), .WORD_W (DW),
        .ADDR_W   (AW),    .SEL_W   (SEL_W), .SHORT_N(SHORT_N)
    ) u_rd (
        .addr    (reg_addr),
        .pend_p  (pend_p),
        .pend_l  (pend_l),
        .pmask   (pen_mask),
        .lmask   (len_mask),
        .fiq_en  (fiq_en),
        .fiq_sel (fiq_sel),
        .rdata   (reg_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_out <= 1'b0;
            fiq_out <= 1'b0;
        end else begin
            irq_out <= (|pend_p) | (|pend_l);
            fiq_out <= fiq_en & fiq_raw;
        end
    end
endmodule

// File: rtl/intc2b_chk.sv
module intc2b_chk
    import intc2b_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [WORD_W-1:0]   reg_wdata,
    input logic [PERIPH_N-1:0] pen_mask,
    input logic [LOCAL_N-1:0]  len_mask,
    input logic                fiq_en,
    input logic [SEL_W-1:0]    fiq_sel,
    input logic                irq_out,
    input logic                fiq_out
);
    logic ctl_hit;
    assign ctl_hit = (reg_addr == OFF_FIQ)    || (reg_addr == OFF_ENS_LO)  ||
                     (reg_addr == OFF_ENS_HI) || (reg_addr == OFF_ENS_LOC) ||
                     (reg_addr == OFF_ENC_LO) || (reg_addr == OFF_ENC_HI)  ||
                     (reg_addr == OFF_ENC_LOC);

    a_r2_set_keeps_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_ENS_LO) |=>
        ((pen_mask[31:0] & $past(reg_wdata)) == $past(reg_wdata)));

    a_r3_clear_drops_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_ENC_HI) |=>
        ((pen_mask[63:32] & $past(reg_wdata)) == 32'd0));

    a_r7_fiq_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !fiq_en |=> !fiq_out);

    a_r8_sel_empty_low: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_sel >= SEL_W'(PERIPH_N + LOCAL_N)) |=> !fiq_out);

    a_r9_no_enables_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (pen_mask == '0 && len_mask == '0) |=> !irq_out);

    a_r12_stray_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !ctl_hit) |=>
        ($stable(pen_mask) && $stable(len_mask) && $stable(fiq_en) && $stable(fiq_sel)));
endmodule

bind intc2b_top intc2b_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pen_mask  (pen_mask),
    .len_mask  (len_mask),
    .fiq_en    (fiq_en),
    .fiq_sel   (fiq_sel),
    .irq_out   (irq_out),
    .fiq_out   (fiq_out)
);

// File: tb/intc2b_top_test.sv
`timescale 1ns/1ps
module intc2b_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] periph_lvl = '0;
    logic [7:0]  local_lvl = '0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out, fiq_out;

    int checks = 0;
    int errors = 0;

    // Bench model of the control state.
    logic [63:0] m_pen = '0;
    logic [7:0]  m_len = '0;
    logic        m_fen = 1'b0;
    logic [6:0]  m_fsel = '0;

    int sc_list [11] = '{7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62};

    always #5 clk = ~clk;

    intc2b_top uut (
        .clk(clk), .rst_n(rst_n), .periph_lvl(periph_lvl), .local_lvl(local_lvl),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out), .fiq_out(fiq_out)
    );

    function automatic logic [31:0] exp_read(input logic [5:0] a);
        logic [63:0] pp;
        logic [7:0]  pl;
        logic [31:0] r;
        pp = periph_lvl & m_pen;
        pl = local_lvl & m_len;
        case (a)
            6'h00: begin
                r = {22'd0, |pp[63:32], |pp[31:0], pl};
                for (int k = 0; k < 11; k++) r[10+k] = pp[sc_list[k]];
            end
            6'h04: r = pp[31:0];
            6'h08: r = pp[63:32];
            6'h0C: r = {24'd0, m_fen, m_fsel};
            6'h10: r = m_pen[31:0];
            6'h14: r = m_pen[63:32];
            6'h18: r = {24'd0, m_len};
            6'h1C: r = ~m_pen[31:0];
            6'h20: r = ~m_pen[63:32];
            6'h24: r = ~{24'd0, m_len};
            default: r = 32'd0;
        endcase
        return r;
    endfunction

    function automatic string read_tag(input logic [5:0] a);
        case (a)
            6'h00: return "R4/R5";
            6'h04, 6'h08: return "R1";
            6'h0C: return "R6";
            6'h10, 6'h14, 6'h18: return "R2";
            6'h1C, 6'h20, 6'h24: return "R3";
            default: return "R12";
        endcase
    endfunction

    function automatic logic exp_fiq();
        if (!m_fen) return 1'b0;
        if (m_fsel < 7'd64) return periph_lvl[m_fsel[5:0]];
        if (m_fsel < 7'd72) return local_lvl[m_fsel[2:0]];
        return 1'b0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called just after a falling edge with inputs already driven.
    task automatic cycle();
        logic ei, ef;
        #1;
        check(read_tag(reg_addr), reg_rdata, exp_read(reg_addr));
        ei = |(periph_lvl & m_pen) | |(local_lvl & m_len);
        ef = exp_fiq();
        if (reg_wr) begin
            case (reg_addr)
                6'h0C: begin m_fsel = reg_wdata[6:0]; m_fen = reg_wdata[7]; end
                6'h10: m_pen[31:0]  = m_pen[31:0]  | reg_wdata;
                6'h14: m_pen[63:32] = m_pen[63:32] | reg_wdata;
                6'h18: m_len = m_len | reg_wdata[7:0];
                6'h1C: m_pen[31:0]  = m_pen[31:0]  & ~reg_wdata;
                6'h20: m_pen[63:32] = m_pen[63:32] & ~reg_wdata;
                6'h24: m_len = m_len & ~reg_wdata[7:0];
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        check("R9/R10 irq", {31'd0, irq_out}, {31'd0, ei});
        check("R7/R8/R10 fiq", {31'd0, fiq_out}, {31'd0, ef});
    endtask

    task automatic drive(input logic [63:0] p, input logic [7:0] l, input logic w,
                         input logic [5:0] a, input logic [31:0] d);
        periph_lvl = p; local_lvl = l; reg_wr = w; reg_addr = a; reg_wdata = d;
        cycle();
    endtask

    logic [5:0] defined_offs [10] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10,
                                      6'h14, 6'h18, 6'h1C, 6'h20, 6'h24};

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd7351));
        // R11: reset state
        periph_lvl = '1; local_lvl = '1;
        reg_addr = 6'h10;
        #23;
        check("R11 ens_lo", reg_rdata, 32'd0);
        check("R11 irq", {31'd0, irq_out}, 32'd0);
        check("R11 fiq", {31'd0, fiq_out}, 32'd0);
        reg_addr = 6'h0C; #1;
        check("R11 fiq_ctl", reg_rdata, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corner cases.
        drive(64'h0, 8'h0, 1, 6'h10, 32'hFFFF_FFFF);             // R2
        drive(64'h0, 8'h0, 1, 6'h1C, 32'h0000_00F0);             // R3
        drive(64'h1, 8'h0, 1, 6'h24, 32'hFFFF_FFFF);             // R3 inverse
        drive(64'h1, 8'h0, 0, 6'h24, 32'h0);
        drive(64'h1, 8'h0, 1, 6'h0C, 32'h0000_0080);             // R7 select 0
        drive(64'h0, 8'h0, 1, 6'h0C, 32'h0000_00BF);             // select 63
        drive(64'h8000_0000_0000_0000, 8'h0, 1, 6'h0C, 32'h0000_00C0); // select 64
        drive(64'h0, 8'h01, 1, 6'h0C, 32'h0000_00C7);            // select 71
        drive(64'h0, 8'h80, 1, 6'h0C, 32'h0000_00C8);            // R8 select 72
        drive(64'h0, 8'hFF, 1, 6'h0C, 32'h0000_00FF);            // R8 select 127
        drive('1, 8'hFF, 1, 6'h00, 32'hFFFF_FFFF);               // R12 pending write
        drive('1, 8'hFF, 1, 6'h28, 32'hFFFF_FFFF);               // R12 undefined
        drive('1, 8'hFF, 1, 6'h11, 32'hFFFF_FFFF);               // R12 unaligned
        drive('1, 8'hFF, 0, 6'h3C, 32'h0);
        drive(64'h8000_0000_0000_0000, 8'h0, 1, 6'h14, 32'hFFFF_FFFF); // R4 bit 9
        drive(64'h4000_0000_0000_0000, 8'h0, 0, 6'h00, 32'h0);   // R5 src 62
        drive(64'h0000_0000_0000_0080, 8'h0, 0, 6'h00, 32'h0);   // R5 src 7

        // Random stimulus.
        for (int n = 0; n < 4000; n++) begin
            logic [63:0] p;
            logic [7:0]  l;
            logic [5:0]  a;
            logic [31:0] d;
            case ($urandom % 3)
                0: p = {$urandom, $urandom};
                1: p = {$urandom & $urandom & $urandom, $urandom & $urandom & $urandom};
                default: p = 64'd1 << ($urandom % 64);
            endcase
            l = 8'($urandom & $urandom);
            if ($urandom % 4 == 0) a = 6'($urandom);
            else a = defined_offs[$urandom % 10];
            d = (a == 6'h0C) ? {24'd0, 1'($urandom % 4 != 0), 7'($urandom)}
                             : $urandom & $urandom;
            drive(p, l, 1'($urandom % 3 == 0), a, d);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule